// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the SCL clock of an I2C master. It pulls the line low for a programmed number of count ticks and then releases it. It waits until the synchronised line level actually reads high, and then holds the high phase for a second programmed number of ticks. A count tick is the functional clock divided by a programmable clocks-per-count value. The time spent waiting for the line to rise is never counted. Slow rise times and slaves that stretch the clock therefore only lengthen the released interval and never shorten the high phase. The low count starts on the very cycle the pull begins, so software must size it to include the line fall time.

Each count is nine bits wide. The lower eight bits come from a dedicated byte input. The ninth bit of each count is taken from a separate extension byte: bit 7 extends the low count and bit 6 extends the high count. A library parameter can remove the ninth bit. The same high count also serves as the hold time of a START condition, because the byte engine pulls SDA while SCL is high and waits for the next falling strobe. Two one-cycle strobes mark the start of each low phase and each high phase for the byte engine.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, one cycle after it was sampled low, `scl_drive_low` is 0 and both strobes are 0. The counters are held cleared.
- R2: A low phase keeps `scl_drive_low` at 1 for exactly effL*D clock cycles, counted from its first cycle. effL is the low count and D is the effective clocks-per-count.
- R3: After SCL is released, the high phase begins exactly SYNC_STAGES+1 cycles after the first cycle in which `scl_in` reads 1. With the default of 2 stages this is 3 cycles. The high phase then lasts effH*D cycles, ending in the cycle before the next low phase.
- R4: While the line stays low after release, as when a slave stretches the clock, no high phase starts. `scl_drive_low` stays 0 and no strobe is issued.
- R5: The low count is {count_ext[7], low_count_byte} and the high count is {count_ext[6], high_count_byte}. The maximum count is 0x1FF. Bits 5..0 of `count_ext` have no effect.
- R6: A programmed count of 0 behaves exactly like a count of 1.
- R7: A `clks_per_count` value of 0 behaves like 1. A value D of 1 or more stretches each count to D clock cycles.
- R8: `scl_fall_stb` is high for exactly the first cycle of each low phase, and `scl_drive_low` is 1 in that cycle. `scl_rise_stb` is high for exactly the first cycle of each high phase, and the line is released in that cycle and in the cycle before it. The two strobes are never high together.
- R9: When `enable` is raised, a low phase with `scl_fall_stb` starts on the next cycle. Dropping `enable` in any cycle, including the final cycle of a phase, returns the block to the released idle state on the next cycle, with no strobe. Re-enabling starts a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator. When low, SCL is released |
| low_count_byte | input | 8 | Low-phase count, bits 7..0 |
| high_count_byte | input | 8 | High-phase count, bits 7..0 |
| count_ext | input | 8 | Bit 7 = low count bit 8, bit 6 = high count bit 8 |
| clks_per_count | input | 4 | Functional clocks per count tick (0 acts as 1) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_fall_stb | output | 1 | One-cycle strobe at the start of a low phase |
| scl_rise_stb | output | 1 | One-cycle strobe at the start of a high phase |

## Verification
Two events can fall in the same cycle: the terminal tick of a high phase, which would start the next low phase, and the deassertion of `enable`. The bench computes the last high cycle from the programmed counts and the divider, and drops `enable` exactly in that cycle. The shutdown must win: in the next cycle the line is released and no falling strobe appears. The same sweep also makes a slave release of the stretched line coincide with the synchroniser's arrival. The bench judges this by the exact number of released cycles before the rising strobe.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

   // Phase of the generated SCL waveform
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,   // generator disabled, line released
      PH_LOW  = 2'd1,   // line pulled low, low count running
      PH_WAIT = 2'd2,   // line released, waiting for it to read high
      PH_HIGH = 2'd3    // line high, high count running
   } scl_phase_e;

endpackage

// File: rtl/scl_tick_div.sv
// Count-clock prescaler: one tick every div functional clocks (0 acts as 1).
module scl_tick_div #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] last;

   always_comb last = (div == '0) ? '0 : div - 1'b1;

   assign tick = (pre_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (clr || tick)   pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/scl_phase_timer.sv
// Shared phase counter: done on the tick that completes limit ticks (0 acts as 1).
module scl_phase_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          done
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] eff;

   always_comb eff = (limit == '0) ? CW'(1) : limit;

   assign done = tick && (cnt_q >= eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/scl_line_sync.sv
// Multi-stage synchroniser for the sensed SCL level; idles high.
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= {sr_q[STAGES-2:0], d};
   end

   assign q = sr_q[STAGES-1];
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter bit EXT_EN      = 1'b1,
   parameter int EXT_LO_POS  = 7,
   parameter int EXT_HI_POS  = 6,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [BYTE_W-1:0] low_count_byte,
   input  logic [BYTE_W-1:0] high_count_byte,
   input  logic [BYTE_W-1:0] count_ext,
   input  logic [DIV_W-1:0]  clks_per_count,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              scl_fall_stb,
   output logic              scl_rise_stb
);
   localparam int CW = BYTE_W + (EXT_EN ? 1 : 0);

   // Elaboration-time parameter checks
   if (BYTE_W < 2)      $error("BYTE_W must be at least 2");
   if (DIV_W < 1)       $error("DIV_W must be at least 1");
   if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   if (EXT_LO_POS >= BYTE_W || EXT_HI_POS >= BYTE_W || EXT_LO_POS == EXT_HI_POS)
      $error("extension bit positions invalid");

   logic [CW-1:0] lo_cnt, hi_cnt, cur_limit;

   // Count assembly: with or without the ninth bits
   if (EXT_EN) begin : g_ext
      assign lo_cnt = {count_ext[EXT_LO_POS], low_count_byte};
      assign hi_cnt = {count_ext[EXT_HI_POS], high_count_byte};
      logic unused_ext;
      assign unused_ext = ^count_ext;
   end else begin : g_noext
      assign lo_cnt = low_count_byte;
      assign hi_cnt = high_count_byte;
      logic unused_ext;
      assign unused_ext = ^count_ext;
   end

   scl_phase_e state_q, state_d;
   logic       clr, tick, done, line_hi, seen_low_q;
   logic       fall_q, rise_q;

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(line_hi)
   );

   scl_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(clr), .div(clks_per_count), .tick(tick)
   );

   assign cur_limit = (state_q == PH_HIGH) ? hi_cnt : lo_cnt;

   scl_phase_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
      .limit(cur_limit), .done(done)
   );

   // Phase sequencing; disable has priority over any phase end
   always_comb begin
      state_d = state_q;
      if (!enable) state_d = PH_OFF;
      else begin
         unique case (state_q)
            PH_OFF:  state_d = PH_LOW;
            PH_LOW:  if (done) state_d = PH_WAIT;
            PH_WAIT: if (line_hi && seen_low_q) state_d = PH_HIGH;
            PH_HIGH: if (done) state_d = PH_LOW;
            default: state_d = PH_OFF;
         endcase
      end
   end

   // Counters restart at every phase change and stay cleared while off
   assign clr = (state_d != state_q) || (state_q == PH_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PH_OFF;
         seen_low_q <= 1'b0;
         fall_q     <= 1'b0;
         rise_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         fall_q  <= (state_d == PH_LOW)  && (state_q != PH_LOW);
         rise_q  <= (state_d == PH_HIGH) && (state_q != PH_HIGH);
         // Stale high samples from before the pull must not end the wait
         if ((state_d == PH_LOW) && (state_q != PH_LOW)) seen_low_q <= 1'b0;
         else if (!line_hi)                              seen_low_q <= 1'b1;
      end
   end

   assign scl_drive_low = (state_q == PH_LOW);
   assign scl_fall_stb  = fall_q;
   assign scl_rise_stb  = rise_q;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_drive_low,
   input logic scl_fall_stb,
   input logic scl_rise_stb
);
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !scl_fall_stb && !scl_rise_stb))
      else $error("disabled generator still active");

   p_pull_has_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> scl_fall_stb)
      else $error("low phase started without falling strobe");

   p_rise_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |-> (!scl_drive_low && !$past(scl_drive_low)))
      else $error("high phase entered without a released wait");

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_fall_stb && scl_rise_stb))
      else $error("both strobes high");

   p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb |=> !scl_fall_stb)
      else $error("falling strobe longer than one cycle");

   p_fall_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb |-> scl_drive_low)
      else $error("falling strobe while line released");
endmodule

bind scl_timing_gen scl_timing_chk u_scl_timing_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable),
   .scl_drive_low(scl_drive_low), .scl_fall_stb(scl_fall_stb),
   .scl_rise_stb(scl_rise_stb)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LIM        = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [7:0] lo_b = '0, hi_b = '0, ext = '0;
   logic [3:0] cpc = '0;
   logic       stretch = 1'b0;
   logic       drv, fstb, rstb, scl_in;
   int         n_chk = 0, n_err = 0;

   assign scl_in = ~drv & ~stretch;   // wired-AND line with a stretching slave

   always #(CLK_PERIOD/2) clk = ~clk;

   scl_timing_gen u_scl_timing_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .low_count_byte(lo_b), .high_count_byte(hi_b), .count_ext(ext),
      .clks_per_count(cpc), .scl_in(scl_in),
      .scl_drive_low(drv), .scl_fall_stb(fstb), .scl_rise_stb(rstb)
   );

   function automatic int eff(int n);
      return (n == 0) ? 1 : n;
   endfunction

   task automatic check(bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // Entered at the negedge of a cycle showing the falling strobe; leaves at the next one.
   task automatic run_period(int nl, int nh, int d, int k, string tag);
      int c;
      c = 0;
      if (k > 0) stretch = 1'b1;
      while (drv && c < LIM) begin
         if (rstb) check(0, {"R8 rise strobe in low phase ", tag}, 1, 0);
         c++;
         @(negedge clk);
      end
      check(c == nl*d, {"R2 low length ", tag}, c, nl*d);
      c = 0;
      while (!rstb && c < LIM) begin
         if (c == k) stretch = 1'b0;
         if (drv || fstb) check(0, {"R4 activity while line held low ", tag}, 1, 0);
         c++;
         @(negedge clk);
      end
      stretch = 1'b0;
      check(c == k + SYNC + 1, {"R3 R4 released wait length ", tag}, c, k + SYNC + 1);
      c = 0;
      while (!fstb && c < LIM) begin
         if (c > 0 && rstb) check(0, {"R8 rise strobe too long ", tag}, 1, 0);
         if (drv) check(0, {"R3 line pulled in high phase ", tag}, 1, 0);
         c++;
         @(negedge clk);
      end
      check(c == nh*d, {"R3 high length ", tag}, c, nh*d);
      check(drv == 1'b1, {"R8 fall strobe with pull ", tag}, drv, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!drv && !fstb && !rstb, "R1 reset state", {drv, fstb, rstb}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep low count, high count, prescale and stretch length
      for (int nl = 0; nl <= 4; nl++) begin
         for (int nh = 0; nh <= 4; nh++) begin
            for (int p = 0; p <= 3; p++) begin
               string tag;
               int k;
               k = ((nl + nh + p) % 3) * 2;
               tag = $sformatf("R6 R7 nl=%0d nh=%0d cpc=%0d k=%0d", nl, nh, p, k);
               enable = 1'b0;
               lo_b = 8'(nl); hi_b = 8'(nh); ext = '0; cpc = 4'(p);
               @(negedge clk); @(negedge clk);
               check(!drv && !fstb && !rstb, {"R1 idle ", tag}, {drv, fstb, rstb}, 0);
               enable = 1'b1;
               @(negedge clk);
               check(fstb && drv, {"R9 start after enable ", tag}, {fstb, drv}, 3);
               run_period(eff(nl), eff(nh), eff(p), k, tag);
               run_period(eff(nl), eff(nh), eff(p), 0, tag);
            end
         end
      end

      // Ninth bits
      enable = 1'b0; lo_b = 8'd2; hi_b = 8'd1; ext = 8'hC0; cpc = 4'd1;
      @(negedge clk); @(negedge clk);
      enable = 1'b1; @(negedge clk);
      run_period(258, 257, 1, 0, "R5 both ninth bits");
      ext = 8'h7F; @(negedge clk);  // applied for the next period, from a low phase
      enable = 1'b0; @(negedge clk); enable = 1'b1; @(negedge clk);
      run_period(2, 257, 1, 0, "R5 high ninth only, low ext bits ignored");
      enable = 1'b0; ext = 8'hBF; @(negedge clk); enable = 1'b1; @(negedge clk);
      run_period(258, 1, 1, 0, "R5 low ninth only, low ext bits ignored");

      // Disable in the final high cycle: disable must win
      enable = 1'b0; lo_b = 8'd2; hi_b = 8'd3; ext = '0; cpc = 4'd2;
      @(negedge clk); @(negedge clk);
      enable = 1'b1; @(negedge clk);
      begin
         int c;
         c = 0;
         while (!rstb && c < LIM) begin c++; @(negedge clk); end
         repeat (3*2 - 1) @(negedge clk);
         check(!drv && !fstb, "R9 still high in last cycle", {drv, fstb}, 0);
         enable = 1'b0;
         @(negedge clk);
         check(!drv && !fstb && !rstb, "R9 disable beats phase end", {drv, fstb, rstb}, 0);
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!drv && !fstb && !rstb, "R1 stays idle", {drv, fstb, rstb}, 0);
         end
      end

      // Disable in the middle of a low phase, then restart
      enable = 1'b1; @(negedge clk);
      check(fstb, "R9 start strobe", fstb, 1);
      @(negedge clk);
      enable = 1'b0; @(negedge clk);
      check(!drv, "R9 mid-low disable releases", drv, 0);
      enable = 1'b1; @(negedge clk);
      check(fstb && drv, "R9 restart strobe", {fstb, drv}, 3);
      run_period(2, 3, 2, 0, "R9 full length after restart");

      summary();
      $finish;
   end
endmodule